// File: doc/BRIEF.md
# Link-Side Status Word Serializer

This block moves 16-bit status words from the physical-layer side of a serial bus node to its link controller. The words come from the register-read path or from event sources, which share one request port. Each word goes out over a narrow data lane, two bits per clock. While the word is on the lane, the control lane carries the status code. Nothing is sent until the interface reports that it is idle.

An incoming packet must always reach the link before anything else. If one arrives, the packet path raises a preempt input and the serializer drops the control lane back to idle. The word stays in place and is sent again from its first bit pair at the next opportunity, until all of it has been delivered.

A one-entry buffer sits behind the word being sent, so a second request can be accepted while the first is still in flight. A done pulse marks each word that was delivered in full. A busy output stays high while any word is outstanding.

Top module: `stat_xfer_ser`

## Requirements
- R1: While `rst_n` is low, `ctl_out` is 00, `d_out` is 00, `busy` and `done` are 0, and `req_ready` is 1.
- R2: A transfer begins (`ctl_out` goes from 00 to 01) exactly at the first clock edge where a word is outstanding, no transfer is running, `bus_idle` is 1 and `rx_preempt` is 0.
- R3: `ctl_out` only ever takes the values 01 (status cycle) or 00 (idle), and `d_out` is 00 in every cycle where `ctl_out` is 00.
- R4: In the k-th status cycle of a transfer (k counted from 0), `d_out[0]` carries word bit 2k and `d_out[1]` carries word bit 2k+1, so bit 0 goes out first.
- R5: A transfer with no preemption lasts exactly 8 consecutive status cycles. No run of status cycles is ever longer than 8, and a run ends early only through preemption.
- R6: If `rx_preempt` is 1 during a status cycle, `ctl_out` is 00 in the next cycle.
- R7: A preempted word stays at the head of the queue and is sent again later, starting from bit pair 0.
- R8: Two transfers are always separated by at least one cycle with `ctl_out` at 00. The cycle that carries `done` is such an idle cycle.
- R9: `done` is high for exactly one cycle, the cycle right after the 8th status cycle of a transfer in which `rx_preempt` stayed 0. It is never high at any other time.
- R10: At most two words are held: the one being sent and one buffered. `req_ready` is 1 exactly when fewer than two are held. A request presented while `req_ready` is 0 is ignored and never sent.
- R11: `busy` is 1 exactly while at least one word is held. Words are delivered in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A status word is offered |
| req_word | input | 16 | Status word to send (WORD_W) |
| req_ready | output | 1 | The offered word is taken at this edge |
| bus_idle | input | 1 | The link interface is idle and may be claimed |
| rx_preempt | input | 1 | A received packet must take over the interface |
| ctl_out | output | 2 | Control lane code: 01 status, 00 idle |
| d_out | output | 2 | Data lane, one bit pair per cycle (LANE_W) |
| busy | output | 1 | At least one word is held |
| done | output | 1 | One-cycle pulse after a word is fully delivered |

## Verification
The assertions assume that the request port is used as a valid/ready pair, with a word counted only when `req_valid` and `req_ready` are both high at an edge. They also assume that `bus_idle` and `rx_preempt` are synchronous and settle before each edge. The stimulus changes every input only at the falling edge. It draws `bus_idle` and `rx_preempt` at random so that starts get held back and preemptions land on every bit pair, including the last. Requests are offered often enough that the buffer fills and some requests are refused.

// File: rtl/stat_xfer_pkg.sv
package stat_xfer_pkg;

   // Control lane codes driven by the serializer side of the interface
   typedef enum logic [1:0] {
      CTL_IDLE   = 2'b00,
      CTL_STATUS = 2'b01,
      CTL_RECV   = 2'b10,
      CTL_GRANT  = 2'b11
   } ctl_code_e;

endpackage

// File: rtl/stat_word_slot.sv
// Holds the word in flight plus an optional one-entry buffer behind it.
module stat_word_slot #(
   parameter int WORD_W  = 16,
   parameter int HAS_BUF = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] push_word,
   input  logic              pop,
   output logic              head_valid,
   output logic [WORD_W-1:0] head_word,
   output logic              can_take
);

   logic              act_v;
   logic [WORD_W-1:0] act_w;

   assign head_valid = act_v;
   assign head_word  = act_w;

   if (HAS_BUF != 0) begin : g_buf
      logic              pend_v;
      logic [WORD_W-1:0] pend_w;

      assign can_take = !pend_v;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_v  <= 1'b0;
            act_w  <= '0;
            pend_v <= 1'b0;
            pend_w <= '0;
         end else if (pop) begin
            if (pend_v) begin
               act_w  <= pend_w;
               pend_v <= 1'b0;
            end else begin
               act_v <= push;
               act_w <= push_word;
            end
         end else if (push) begin
            if (act_v) begin
               pend_v <= 1'b1;
               pend_w <= push_word;
            end else begin
               act_v <= 1'b1;
               act_w <= push_word;
            end
         end
      end
   end else begin : g_nobuf
      assign can_take = !act_v;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_v <= 1'b0;
            act_w <= '0;
         end else if (pop) begin
            act_v <= 1'b0;
         end else if (push) begin
            act_v <= 1'b1;
            act_w <= push_word;
         end
      end
   end

endmodule

// File: rtl/stat_beat_seq.sv
// Start/abort/finish control and bit-pair counter for one transfer.
module stat_beat_seq #(
   parameter int BEATS = 8,
   localparam int BW   = $clog2(BEATS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          word_ready,
   input  logic          bus_idle,
   input  logic          rx_preempt,
   output logic          sending,
   output logic [BW-1:0] beat,
   output logic          finish,
   output logic          done
);

   localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

   assign finish = sending && !rx_preempt && (beat == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sending <= 1'b0;
         beat    <= '0;
         done    <= 1'b0;
      end else begin
         done <= finish;
         if (!sending) begin
            if (word_ready && bus_idle && !rx_preempt) begin
               sending <= 1'b1;
               beat    <= '0;
            end
         end else if (rx_preempt || beat == LAST) begin
            sending <= 1'b0;
            beat    <= '0;
         end else begin
            beat <= beat + 1'b1;
         end
      end
   end

endmodule

// File: rtl/stat_lane_mux.sv
// Picks the bit pair of the current beat, forced to zero when not sending.
module stat_lane_mux #(
   parameter int WORD_W = 16,
   parameter int LANE_W = 2,
   localparam int BEATS = WORD_W / LANE_W,
   localparam int BW    = $clog2(BEATS)
) (
   input  logic [WORD_W-1:0] word,
   input  logic [BW-1:0]     beat,
   input  logic              en,
   output logic [LANE_W-1:0] lane
);

   logic [LANE_W-1:0] slices [BEATS];

   for (genvar g = 0; g < BEATS; g++) begin : g_slice
      assign slices[g] = word[g*LANE_W +: LANE_W];
   end

   assign lane = en ? slices[beat] : '0;

endmodule

// File: rtl/stat_xfer_ser.sv
module stat_xfer_ser
   import stat_xfer_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int LANE_W  = 2,
   parameter int HAS_BUF = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [WORD_W-1:0] req_word,
   output logic              req_ready,
   input  logic              bus_idle,
   input  logic              rx_preempt,
   output logic [1:0]        ctl_out,
   output logic [LANE_W-1:0] d_out,
   output logic              busy,
   output logic              done
);

   localparam int BEATS = WORD_W / LANE_W;
   localparam int BW    = $clog2(BEATS);

   if (LANE_W < 1 || (WORD_W % LANE_W) != 0) begin : g_bad_split
      $error("WORD_W must be a whole multiple of LANE_W");
   end
   if (BEATS < 2) begin : g_bad_beats
      $error("a word must span at least two beats");
   end
   if (HAS_BUF != 0 && HAS_BUF != 1) begin : g_bad_buf
      $error("HAS_BUF must be 0 or 1");
   end

   logic              head_valid;
   logic [WORD_W-1:0] head_word;
   logic              sending;
   logic [BW-1:0]     beat;
   logic              finish;
   logic              push;

   assign push = req_valid && req_ready;

   stat_word_slot #(.WORD_W(WORD_W), .HAS_BUF(HAS_BUF)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_word (req_word),
      .pop       (finish),
      .head_valid(head_valid),
      .head_word (head_word),
      .can_take  (req_ready)
   );

   stat_beat_seq #(.BEATS(BEATS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_ready(head_valid),
      .bus_idle  (bus_idle),
      .rx_preempt(rx_preempt),
      .sending   (sending),
      .beat      (beat),
      .finish    (finish),
      .done      (done)
   );

   stat_lane_mux #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_mux (
      .word(head_word),
      .beat(beat),
      .en  (sending),
      .lane(d_out)
   );

   assign ctl_out = sending ? CTL_STATUS : CTL_IDLE;
   assign busy    = head_valid;

endmodule

// File: rtl/stat_xfer_ser_chk.sv
module stat_xfer_ser_chk
   import stat_xfer_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int LANE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              bus_idle,
   input logic              rx_preempt,
   input logic [1:0]        ctl_out,
   input logic [LANE_W-1:0] d_out,
   input logic              busy,
   input logic              done
);

   localparam int BEATS = WORD_W / LANE_W;
   localparam int RW    = $clog2(BEATS + 1) + 1;

   // Length of the current or just-ended status run, and whether it was cut
   logic [RW-1:0] run_q;
   logic          cut_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         cut_q <= 1'b0;
      end else if (ctl_out == CTL_STATUS) begin
         run_q <= run_q + 1'b1;
         cut_q <= cut_q | rx_preempt;
      end else begin
         run_q <= '0;
         cut_q <= 1'b0;
      end
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (ctl_out == CTL_IDLE && d_out == '0 && !busy && !done && req_ready));

   assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_out == CTL_STATUS && $past(ctl_out) != CTL_STATUS)
         |-> ($past(bus_idle) && !$past(rx_preempt)));

   assert_ctl_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_out == CTL_IDLE || ctl_out == CTL_STATUS));

   assert_idle_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_out == CTL_IDLE |-> d_out == '0);

   assert_run_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RW'(BEATS));

   assert_preempt_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_out == CTL_STATUS && rx_preempt) |=> ctl_out == CTL_IDLE);

   assert_done_after_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ctl_out == CTL_IDLE && run_q == RW'(BEATS) && !cut_q));

   assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy);

   assert_idle_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> req_ready);

   assert_busy_drop_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

bind stat_xfer_ser stat_xfer_ser_chk #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/stat_xfer_ser_tb.sv
module stat_xfer_ser_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WORD_W     = 16;
   localparam int LANE_W     = 2;
   localparam int BEATS      = WORD_W / LANE_W;
   localparam logic [1:0] C_IDLE = 2'b00;
   localparam logic [1:0] C_STAT = 2'b01;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic [WORD_W-1:0] req_word;
   logic              req_ready;
   logic              bus_idle;
   logic              rx_preempt;
   logic [1:0]        ctl_out;
   logic [LANE_W-1:0] d_out;
   logic              busy;
   logic              done;

   stat_xfer_ser #(.WORD_W(WORD_W), .LANE_W(LANE_W), .HAS_BUF(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
      .req_ready(req_ready), .bus_idle(bus_idle), .rx_preempt(rx_preempt),
      .ctl_out(ctl_out), .d_out(d_out), .busy(busy), .done(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   logic [WORD_W-1:0] mq[$];
   logic [1:0] prev_ctl;
   int run;
   int occ_pre_edge;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   function automatic logic [LANE_W-1:0] pair_of(input logic [WORD_W-1:0] w, input int k);
      return w[k*LANE_W +: LANE_W];
   endfunction

   task automatic observe();
      bit exp_done, exp_start;
      exp_done = (prev_ctl == C_STAT) && (run == BEATS) && !rx_preempt;
      chk(done == exp_done, "R9 done pulse", 32'(done), 32'(exp_done));
      if (exp_done) begin
         chk(ctl_out == C_IDLE, "R8 idle in done cycle", 32'(ctl_out), 32'(C_IDLE));
         void'(mq.pop_front());
      end
      exp_start = (prev_ctl != C_STAT) && (occ_pre_edge > 0) && bus_idle && !rx_preempt;
      chk((ctl_out == C_STAT && prev_ctl != C_STAT) == exp_start, "R2 start",
          32'(ctl_out), 32'(exp_start));
      if (prev_ctl == C_STAT && rx_preempt)
         chk(ctl_out == C_IDLE, "R6 preempt release", 32'(ctl_out), 32'(C_IDLE));
      if (prev_ctl == C_STAT && ctl_out != C_STAT)
         chk(run == BEATS || rx_preempt, "R5 run length", 32'(run), 32'(BEATS));
      if (ctl_out == C_STAT) begin
         if (prev_ctl != C_STAT) run = 0;
         chk(run < BEATS, "R5 run too long", 32'(run), 32'(BEATS));
         if (mq.size() > 0)
            chk(d_out == pair_of(mq[0], run), "R4/R7 bit pair", 32'(d_out), 32'(pair_of(mq[0], run)));
         else
            chk(1'b0, "R11 status with empty queue", 32'(ctl_out), 32'(C_IDLE));
         run++;
      end else begin
         chk(ctl_out == C_IDLE && d_out == '0, "R3 idle lanes", {ctl_out, 14'd0, 14'd0, d_out}, 32'd0);
      end
      chk(req_ready == (mq.size() < 2), "R10 ready", 32'(req_ready), 32'(mq.size() < 2));
      chk(busy == (mq.size() > 0), "R11 busy", 32'(busy), 32'(mq.size() > 0));
      prev_ctl = ctl_out;
   endtask

   task automatic drive(input bit v, input logic [WORD_W-1:0] w, input bit idle, input bit pre);
      occ_pre_edge = mq.size();
      req_valid  = v;
      req_word   = w;
      bus_idle   = idle;
      rx_preempt = pre;
      if (v && req_ready) mq.push_back(w);
      @(negedge clk);
      observe();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd7741));
      rst_n = 1'b0; req_valid = 1'b0; req_word = '0; bus_idle = 1'b0; rx_preempt = 1'b0;
      prev_ctl = C_IDLE; run = 0; occ_pre_edge = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ctl_out == C_IDLE && d_out == '0, "R1 lanes", {30'd0, ctl_out}, 32'd0);
      chk(!busy && !done && req_ready, "R1 flags", {29'd0, busy, done, req_ready}, 32'd1);
      rst_n = 1'b1;

      // Word held back while the interface is busy (R2), then sent (R4, R9)
      drive(1'b1, 16'hA5C3, 1'b0, 1'b0);
      repeat (4) drive(1'b0, '0, 1'b0, 1'b0);
      repeat (12) drive(1'b0, '0, 1'b1, 1'b0);

      // Fill buffer; third offer refused and never sent (R10, R11)
      drive(1'b1, 16'h1234, 1'b1, 1'b0);
      drive(1'b1, 16'hBEEF, 1'b1, 1'b0);
      drive(1'b1, 16'hDEAD, 1'b1, 1'b0);
      chk(mq.size() == 2, "R10 refused offer", 32'(mq.size()), 32'd2);
      repeat (25) drive(1'b0, '0, 1'b1, 1'b0);

      // Preempt in the middle of a word, then retry (R6, R7)
      drive(1'b1, 16'h0F96, 1'b1, 1'b0);
      repeat (4) drive(1'b0, '0, 1'b1, 1'b0);
      drive(1'b0, '0, 1'b1, 1'b1);
      repeat (20) drive(1'b0, '0, 1'b1, 1'b0);

      // Preempt on the final bit pair: no done, full resend (R9, R7)
      drive(1'b1, 16'hC3A5, 1'b1, 1'b0);
      repeat (8) drive(1'b0, '0, 1'b1, 1'b0);
      drive(1'b0, '0, 1'b1, 1'b1);
      repeat (20) drive(1'b0, '0, 1'b1, 1'b0);

      // Constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         drive(($urandom % 100) < 35, WORD_W'($urandom), ($urandom % 100) < 80, ($urandom % 100) < 6);
      end

      repeat (40) drive(1'b0, '0, 1'b1, 1'b0);
      chk(mq.size() == 0 && !busy, "R11 drained", 32'(mq.size()), 32'd0);
      finish_run();
   end

endmodule